// File: doc/BRIEF.md
# Receive Byte Queue with Programmable Fill Threshold

This block holds up to 16 received bytes in a circular buffer for a serial port. A deserializer offers bytes on a write stream, and register reads drain them in arrival order on a read stream. A fill threshold, picked from four fixed levels by a two-bit field in a control word, decides when the block raises its receive-full flag. When interrupts are enabled it also raises a receive interrupt. The same control word carries a flush bit that empties the buffer and zeroes every stored byte.

The write stream has no back-pressure. A byte offered while `rx_en` is low, or while the buffer already holds 16 bytes, is dropped with no trace. The read stream is valid/ready. `out_valid` is high whenever the buffer holds at least one byte. `out_data` always shows the entry at the read pointer. A transfer happens in any cycle where `out_ready` is high and `out_valid` is high. `out_ready` while empty is ignored. A push and a pop may happen in the same cycle.

Top module: `rxq_fifo`

## Requirements
- R1: `level` reports the number of stored bytes, 0 to 16. It is 0 after reset. An accepted push (`in_valid` with `rx_en` high and `level` below 16) raises it by one in the next cycle.
- R2: Bytes leave through `out_data` in the order they were accepted, including when the pointers wrap from entry 15 back to entry 0. `out_data` shows the entry at the read pointer in every cycle.
- R3: A push offered while `level` is 16 is discarded. It changes neither the stored data, the count nor the flags.
- R4: While `rx_en` is low, `in_valid` has no effect.
- R5: A pop (`out_ready` high) while `level` is 0 changes nothing. A pop while non-empty advances the read pointer and lowers `level` by one.
- R6: An accepted push and a pop in the same cycle leave `level` unchanged, and both pointers advance.
- R7: A control write (`fctl_we`) loads the threshold from bits 7:6 of `fctl_wdata`. Code 0 selects 1, code 1 selects 4, code 2 selects 8 and code 3 selects 14. After reset the threshold is 1.
- R8: After an accepted push, `rx_full` is set if the new count is at or above the threshold. After a pop, it is cleared if the new count is below the threshold. The threshold used is the one held before that cycle's control write. No other event sets `rx_full`.
- R9: `rx_irq` is set in the same cycle that an accepted push sets the full condition, if `rx_ie` is high. `rx_irq` is low in the cycle after any cycle with `rx_ie` low.
- R10: A control write with bit 1 set (flush) sets `level` to 0, resets both pointers to entry 0 and zeroes every stored byte, so `out_data` reads 0. A push or pop in the same cycle is ignored. The flush itself does not change `rx_full` or `rx_irq`.
- R11: `flag_clr` clears `rx_full` and `rx_irq`, unless an accepted push sets them in the same cycle. In that case the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Byte offered by the deserializer |
| in_data | input | 8 | Offered byte |
| out_valid | output | 1 | Buffer holds at least one byte |
| out_data | output | 8 | Byte at the read pointer |
| out_ready | input | 1 | Pop strobe from a data-register read |
| fctl_we | input | 1 | Control-word write strobe |
| fctl_wdata | input | 8 | Control word: bits 7:6 threshold code, bit 1 flush |
| rx_en | input | 1 | Receive enable |
| rx_ie | input | 1 | Receive interrupt enable |
| flag_clr | input | 1 | Clear strobe for the full flag and interrupt |
| level | output | 5 | Number of stored bytes |
| rx_full | output | 1 | Count reached the threshold |
| rx_irq | output | 1 | Receive interrupt level |

## Verification
The hardest cases to reach from the ports are the collisions. These include a push offered at a count of exactly 16 alongside a pop, and a flush landing on the same cycle as a push and a pop. Another is a threshold change while the flag is already set, so that the flag state disagrees with the new level. Directed fill-and-drain runs at each of the four thresholds walk the count through every value and both wrap points. A long pseudo-random phase with rare flushes, clears and control writes then forces these collisions many times. It compares every output against an arithmetic model in every cycle.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // control word field positions (decoded by the register block neighbour)
  localparam int TRIG_LSB  = 6;
  localparam int FLUSH_BIT = 1;

  typedef enum logic [1:0] {
    TRIG_C0 = 2'd0,
    TRIG_C1 = 2'd1,
    TRIG_C2 = 2'd2,
    TRIG_C3 = 2'd3
  } trig_code_e;
endpackage

// File: rtl/rxq_trig.sv
module rxq_trig #(
  parameter int CNT_W = 5,
  parameter int LVL0  = 1,
  parameter int LVL1  = 4,
  parameter int LVL2  = 8,
  parameter int LVL3  = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       code,
  output logic [CNT_W-1:0] thr
);
  import rxq_pkg::*;

  trig_code_e code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  code_q <= TRIG_C0;
    else if (we) code_q <= trig_code_e'(code);
  end

  always_comb begin
    unique case (code_q)
      TRIG_C0: thr = CNT_W'(LVL0);
      TRIG_C1: thr = CNT_W'(LVL1);
      TRIG_C2: thr = CNT_W'(LVL2);
      default: thr = CNT_W'(LVL3);
    endcase
  end

  AST_TRIG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    we && code == 2'd3 |=> thr == CNT_W'(LVL3)); // R7
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 5,
  parameter int PTR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic              flush,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  cnt
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                mem[g] <= '0;
      else if (flush)                            mem[g] <= '0;
      else if (push && wr_ptr == PTR_W'(g))      mem[g] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      unique case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign rdata = mem[rd_ptr];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH)); // R1
  AST_PTR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == CNT_W'(DEPTH) || cnt == '0 || wr_ptr != rd_ptr); // R2
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_ok,
  input  logic             pop_ok,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] thr,
  input  logic             ie,
  input  logic             clr,
  output logic             full,
  output logic             irq
);
  logic [CNT_W-1:0] cnt_after;
  logic             set_ev, drop_ev;

  always_comb begin
    cnt_after = cnt;
    if (push_ok && !pop_ok) cnt_after = cnt + 1'b1;
    if (pop_ok && !push_ok) cnt_after = cnt - 1'b1;
  end

  assign set_ev  = push_ok && (cnt_after >= thr);
  assign drop_ev = pop_ok  && (cnt_after <  thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (set_ev)              full <= 1'b1;
      else if (clr || drop_ev) full <= 1'b0;

      if (!ie)                 irq <= 1'b0;
      else if (set_ev)         irq <= 1'b1;
      else if (clr)            irq <= 1'b0;
    end
  end

  AST_FULL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok && (cnt_after >= thr) |=> full); // R8
  AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |=> !irq); // R9
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !push_ok |=> !full); // R11
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int LVL0   = 1,
  parameter int LVL1   = 4,
  parameter int LVL2   = 8,
  parameter int LVL3   = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready,
  input  logic              fctl_we,
  input  logic [7:0]        fctl_wdata,
  input  logic              rx_en,
  input  logic              rx_ie,
  input  logic              flag_clr,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic              rx_full,
  output logic              rx_irq
);
  import rxq_pkg::*;

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             flush, push_ok, pop_ok;
  logic [CNT_W-1:0] thr;

  assign flush     = fctl_we && fctl_wdata[FLUSH_BIT];
  assign out_valid = (level != '0);
  assign push_ok   = in_valid && rx_en && !flush && (level < CNT_W'(DEPTH));
  assign pop_ok    = out_ready && out_valid && !flush;

  rxq_trig #(.CNT_W(CNT_W), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)) trig_i (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (fctl_we),
    .code  (fctl_wdata[TRIG_LSB +: 2]),
    .thr   (thr)
  );

  rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W), .PTR_W(PTR_W)) store_i (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push_ok),
    .pop   (pop_ok),
    .flush (flush),
    .wdata (in_data),
    .rdata (out_data),
    .cnt   (level)
  );

  rxq_flags #(.CNT_W(CNT_W)) flags_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_ok (push_ok),
    .pop_ok  (pop_ok),
    .cnt     (level),
    .thr     (thr),
    .ie      (rx_ie),
    .clr     (flag_clr),
    .full    (rx_full),
    .irq     (rx_irq)
  );

  AST_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && level == CNT_W'(DEPTH) && !out_ready && !fctl_we |=> $stable(level)); // R3
  AST_RX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en && !out_ready && !fctl_we |=> $stable(level)); // R4
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready && level == '0 && !in_valid |=> level == '0); // R5
  AST_PUSH_POP: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok && pop_ok |=> $stable(level)); // R6
  AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> level == '0 && out_data == '0); // R10
endmodule

// File: tb/rxq_fifo_tb.sv
`timescale 1ns/1ps
module rxq_fifo_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, out_ready = 1'b0, fctl_we = 1'b0;
  logic       rx_en = 1'b0, rx_ie = 1'b0, flag_clr = 1'b0;
  logic [7:0] in_data = '0, fctl_wdata = '0;
  logic       out_valid, rx_full, rx_irq;
  logic [7:0] out_data;
  logic [4:0] level;

  int vectors = 0, errors = 0;

  // reference model
  int   m_mem [16];
  int   m_hd = 0, m_tl = 0, m_cnt = 0, m_thr = 1;
  bit   m_full = 0, m_irq = 0;
  logic [31:0] rng = 32'h1234_5679;

  always #10 clk = ~clk;

  rxq_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .fctl_we(fctl_we), .fctl_wdata(fctl_wdata), .rx_en(rx_en), .rx_ie(rx_ie),
    .flag_clr(flag_clr), .level(level), .rx_full(rx_full), .rx_irq(rx_irq)
  );

  function automatic int thr_of(input int code);
    case (code)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y = x;
    y = y ^ (y << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic check(input string tag);
    vectors++;
    if (level !== 5'(m_cnt) || out_valid !== (m_cnt != 0) ||
        out_data !== 8'(m_mem[m_tl]) || rx_full !== m_full || rx_irq !== m_irq) begin
      errors++;
      $display("FAIL %s R1/R2/R8/R9: level=%0d/%0d data=%02h/%02h full=%0b/%0b irq=%0b/%0b (act/exp)",
               tag, level, m_cnt, out_data, 8'(m_mem[m_tl]), rx_full, m_full, rx_irq, m_irq);
    end
  endtask

  // one clock: drive at negedge, update model, compare after the edge
  task automatic step(input bit v, input int d, input bit rd, input bit we, input int w,
                      input bit en, input bit ie, input bit clr, input string tag);
    bit flush, push_ok, pop_ok, set_ev, drop_ev;
    int after;
    @(negedge clk);
    in_valid = v; in_data = 8'(d); out_ready = rd; fctl_we = we; fctl_wdata = 8'(w);
    rx_en = en; rx_ie = ie; flag_clr = clr;
    flush   = we && w[1];
    push_ok = v && en && !flush && (m_cnt < 16);
    pop_ok  = rd && (m_cnt != 0) && !flush;
    after   = m_cnt + (push_ok ? 1 : 0) - (pop_ok ? 1 : 0);
    set_ev  = push_ok && (after >= m_thr);
    drop_ev = pop_ok && (after < m_thr);
    @(posedge clk);
    #1;
    if (set_ev) m_full = 1; else if (clr || drop_ev) m_full = 0;
    if (!ie) m_irq = 0; else if (set_ev) m_irq = 1; else if (clr) m_irq = 0;
    if (we) m_thr = thr_of((w >> 6) & 3);
    if (flush) begin
      m_cnt = 0; m_hd = 0; m_tl = 0;
      foreach (m_mem[i]) m_mem[i] = 0;
    end else begin
      if (push_ok) begin m_mem[m_hd] = d & 8'hff; m_hd = (m_hd + 1) % 16; end
      if (pop_ok) m_tl = (m_tl + 1) % 16;
      m_cnt = after;
    end
    check(tag);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    foreach (m_mem[i]) m_mem[i] = 0;
    repeat (3) @(posedge clk);
    #1 check("reset R1");
    @(negedge clk) rst_n = 1'b1;
    // R7: reset threshold is 1, a single push sets the flag
    step(1, 8'h5a, 0, 0, 0, 1, 1, 0, "R7 reset threshold");
    step(0, 0, 1, 0, 0, 1, 1, 0, "R8 pop below");
    step(0, 0, 0, 0, 0, 1, 1, 1, "R11 clear");

    // fill and drain at every threshold; 17th push exercises R3, extra pop R5
    for (int code = 0; code < 4; code++) begin
      step(0, 0, 0, 1, (code << 6) | 2, 1, code[0], 0, "R7 R10 flush+trig");
      step(0, 0, 0, 0, 0, 1, code[0], 1, "R11 clear");
      for (int k = 0; k < 17; k++)
        step(1, 8'h30 + k + code * 17, 0, 0, 0, 1, code[0], 0, k == 16 ? "R3 drop at full" : "R1 R8 fill");
      step(1, 8'hee, 1, 0, 0, 1, code[0], 0, "R3 push+pop at full");
      for (int k = 0; k < 17; k++)
        step(0, 0, 1, 0, 0, 1, code[0], 0, k >= 15 ? "R5 pop empty" : "R2 R8 drain");
    end

    // R4: disabled receiver ignores pushes
    for (int k = 0; k < 4; k++) step(1, 8'h77, 0, 0, 0, 0, 1, 0, "R4 rx_en low");
    // R6: steady push+pop
    step(1, 8'h11, 0, 0, 0, 1, 1, 0, "R6 prime");
    for (int k = 0; k < 20; k++) step(1, 8'h40 + k, 1, 0, 0, 1, 1, 0, "R6 push+pop");
    // R10: flush colliding with push and pop, then stored bytes read 0
    step(1, 8'h99, 0, 0, 0, 1, 1, 0, "R10 prime");
    step(1, 8'h98, 1, 1, 8'h42, 1, 1, 0, "R10 flush collision");

    // mixed random traffic
    for (int n = 0; n < 6000; n++) begin
      logic [31:0] r;
      rng = nxt(rng); r = rng;
      step(r[0] | r[1], int'(r[15:8]), r[2] & r[3], r[20:16] == 0, int'(r[31:24]),
           r[5:4] != 0, r[7:6] != 0, r[23:21] == 0, "mix R2 R6 R8 R9 R10 R11");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule